// File: doc/BRIEF.md
# Selectable-Length Twisted-Ring Frequency Divider

This block divides its clock with a twisted-ring shift register. A chain of flip-flops shifts on every clock, and the first stage loads the inverse of a tap stage that a run-time select picks. With n stages in the loop, the pattern repeats every 2n clocks. The tap stage is brought out as a square wave at the clock frequency divided by 2n, with 50% duty.

A dedicated select code fixes the loop at three stages and drives a three-bit output with three square waves spaced a third of a period apart. This gives a simple three-phase clock source. All stage outputs are visible, so the chain can also be decoded as a one-hot-per-pair state counter. Synchronous reset clears every stage. Recovery from corrupted ring states is left to reset.

Top module: `twisted_ring_divider`

## Requirements
- R1: A clock edge with `rst` high clears every bit of `stage_q` and drives `div_out` low.
- R2: Outside reset, on every clock each stage i above 0 loads the value stage i-1 held before the edge. This includes the stages past the selected loop length.
- R3: Outside reset, stage 0 loads the inverse of the tap stage, which is stage n-1. `div_out` always equals that tap stage.
- R4: `len_sel` codes 1 to 5 select a loop length n equal to the code. After reset, `div_out` stays low for n clocks, then goes high for n clocks, and then repeats with period 2n.
- R5: Code 0 selects three-phase mode with n = 3. In this mode `tri_phase[0]` is stage 0, `tri_phase[1]` is stage 2 and `tri_phase[2]` is the inverse of stage 1. Each is a 6-clock, 50% duty wave, and bit 1 lags bit 0 by two clocks, which is 120 degrees.
- R6: Codes greater than `MAX_STAGES` (6 and 7 by default) select the longest loop, n = `MAX_STAGES`.
- R7: `tri_phase` is all zero whenever `len_sel` is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 3 | Loop length code: 0 = three-phase, 1..5 = length, above max = longest |
| stage_q | output | MAX_STAGES | All flip-flop stage outputs, bit 0 first in the chain |
| div_out | output | 1 | Divided square wave, taken from the tap stage |
| tri_phase | output | 3 | Three-phase outputs, active in code 0 only |

## Verification
The bench builds the block with `MAX_STAGES` = 5. With this value, all five length positions appear, and so do the two codes above the maximum that fall back to the longest loop. The three-phase code can then be compared with plain code 3, which has the same loop but muted phase outputs. The bench runs every code from reset for several full periods. It then runs random codes for random lengths, and each run is checked against a closed-form model of every stage, plus rise-to-rise and rise-to-fall interval measurements on `div_out`.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;

    // Width of the loop-length select code.
    localparam int SEL_W = 3;
    // Width of the decoded loop length (supports up to 15 stages).
    localparam int LEN_W = 4;
    // Select code that requests the fixed three-stage, three-phase mode.
    localparam logic [SEL_W-1:0] SEL_TRIPHASE = '0;
    // Loop length used by the three-phase mode.
    localparam int TRI_LEN = 3;

    typedef enum logic [1:0] {
        MODE_LENGTH = 2'd0,   // code picks the length directly
        MODE_TRI    = 2'd1,   // three-phase mode, fixed length
        MODE_CLAMP  = 2'd2    // code beyond range, longest loop
    } loop_mode_e;

    typedef struct packed {
        loop_mode_e       mode;
        logic [LEN_W-1:0] len;
    } tap_cfg_t;

endpackage

// File: rtl/jdiv_tap_decode.sv
module jdiv_tap_decode
    import jdiv_pkg::*;
#(
    parameter int MAX_STAGES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output tap_cfg_t         cfg
);

    always_comb begin
        if (sel == SEL_TRIPHASE) begin
            cfg.mode = MODE_TRI;
            cfg.len  = LEN_W'(TRI_LEN);
        end else if (int'(sel) > MAX_STAGES) begin
            cfg.mode = MODE_CLAMP;
            cfg.len  = LEN_W'(MAX_STAGES);
        end else begin
            cfg.mode = MODE_LENGTH;
            cfg.len  = LEN_W'(sel);
        end
    end

    // R6: an out-of-range code falls back to the longest loop
    p_clamp_longest_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(sel) > MAX_STAGES) |-> (int'(cfg.len) == MAX_STAGES));

endmodule

// File: rtl/jdiv_ring.sv
module jdiv_ring #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fb_src,
    output logic [STAGES-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= ~fb_src;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= {q[STAGES-2:0], ~fb_src};
            end

            // R2: every stage past the first takes its neighbour's old value
            p_shift_chain_r2: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> q[STAGES-1:1] == $past(q[STAGES-2:0]));
        end
    endgenerate

endmodule

// File: rtl/jdiv_phase_tap.sv
module jdiv_phase_tap (
    input  logic       clk,
    input  logic       rst,
    input  logic       tri_en,
    input  logic [2:0] ring3,
    output logic [2:0] tri_phase
);

    // Phase A: stage 0 (0 deg); phase B: stage 2 (120 deg);
    // phase C: stage 1 inverted (60 + 180 = 240 deg).
    always_comb begin
        if (tri_en) tri_phase = {~ring3[1], ring3[2], ring3[0]};
        else        tri_phase = '0;
    end

    // R5: in a legal three-stage cycle the phases are never all equal
    p_tri_mixed_r5: assert property (@(posedge clk) disable iff (rst)
        tri_en |-> ($countones(tri_phase) == 1 || $countones(tri_phase) == 2));

    // R5: phase B lags phase A by two clocks
    p_tri_lag_r5: assert property (@(posedge clk) disable iff (rst)
        (tri_en && $past(tri_en, 2) && !$past(rst) && !$past(rst, 2))
        |-> tri_phase[1] == $past(tri_phase[0], 2));

endmodule

// File: rtl/twisted_ring_divider.sv
module twisted_ring_divider
    import jdiv_pkg::*;
#(
    parameter int MAX_STAGES = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEL_W-1:0]      len_sel,
    output logic [MAX_STAGES-1:0] stage_q,
    output logic                  div_out,
    output logic [2:0]            tri_phase
);

    localparam int RING3_USED = (MAX_STAGES >= TRI_LEN) ? TRI_LEN : MAX_STAGES;

    tap_cfg_t cfg;
    logic     fb_src;
    logic [2:0] ring3;

    jdiv_tap_decode #(.MAX_STAGES(MAX_STAGES)) u_decode (
        .clk (clk),
        .rst (rst),
        .sel (len_sel),
        .cfg (cfg)
    );

    // Tap multiplexer: the last stage of the selected loop feeds back.
    always_comb begin
        fb_src = stage_q[0];
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (cfg.len == LEN_W'(i + 1)) fb_src = stage_q[i];
        end
    end

    jdiv_ring #(.STAGES(MAX_STAGES)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .fb_src (fb_src),
        .q      (stage_q)
    );

    assign div_out = fb_src;

    always_comb begin
        ring3 = '0;
        ring3[RING3_USED-1:0] = stage_q[RING3_USED-1:0];
    end

    jdiv_phase_tap u_phase (
        .clk       (clk),
        .rst       (rst),
        .tri_en    (cfg.mode == MODE_TRI),
        .ring3     (ring3),
        .tri_phase (tri_phase)
    );

    // R1: reset clears the chain and the divided output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stage_q == '0 && !div_out));

    // R3: stage 0 reloads the inverse of the tap seen at the previous edge
    p_feedback_inv_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage_q[0] == !$past(div_out));

endmodule

// File: tb/twisted_ring_divider_test.sv
module twisted_ring_divider_test;

    localparam int MAXS       = 5;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      len_sel = 3'd0;
    logic [MAXS-1:0] stage_q;
    logic            div_out;
    logic [2:0]      tri_phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    twisted_ring_divider #(.MAX_STAGES(MAXS)) uut (
        .clk       (clk),
        .rst       (rst),
        .len_sel   (len_sel),
        .stage_q   (stage_q),
        .div_out   (div_out),
        .tri_phase (tri_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Loop length expected for a code (R4, R5, R6).
    function automatic int exp_len(input logic [2:0] code);
        if (code == 3'd0)      return 3;
        else if (int'(code) > MAXS) return MAXS;
        else                   return int'(code);
    endfunction

    // Closed-form stage values k clocks after reset with loop length n.
    function automatic logic [MAXS-1:0] exp_stages(input int k, input int n);
        logic [MAXS-1:0] v;
        for (int i = 0; i < MAXS; i++) begin
            if (k <= i) v[i] = 1'b0;
            else        v[i] = (((k - i - 1) % (2 * n)) < n);
        end
        return v;
    endfunction

    function automatic string req_of(input logic [2:0] code);
        if (code == 3'd0)           return "R5";
        else if (int'(code) > MAXS) return "R6";
        else                        return "R4";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_code(input logic [2:0] code, input int cycles);
        int n;
        int last_rise;
        logic prev;
        logic [MAXS-1:0] e;
        logic [2:0] et;
        n = exp_len(code);
        @(negedge clk);
        len_sel = code;
        rst     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(stage_q == '0, "R1", "stages after reset", int'(stage_q), 0);
        check(div_out == 1'b0, "R1", "div_out after reset", int'(div_out), 0);
        rst = 1'b0;
        last_rise = -1;
        prev = 1'b0;
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk);
            @(negedge clk);
            e = exp_stages(k, n);
            check(stage_q == e, "R2", "stage vector", int'(stage_q), int'(e));
            check(div_out == e[n-1], "R3", "div_out equals tap",
                  int'(div_out), int'(e[n-1]));
            et = (code == 3'd0) ? {~e[1], e[2], e[0]} : 3'b000;
            check(tri_phase == et, (code == 3'd0) ? "R5" : "R7", "tri_phase",
                  int'(tri_phase), int'(et));
            if (div_out && !prev) begin
                if (last_rise < 0)
                    check(k == n, req_of(code), "first rise clock", k, n);
                else
                    check(k - last_rise == 2 * n, req_of(code), "period",
                          k - last_rise, 2 * n);
                last_rise = k;
            end
            if (!div_out && prev && last_rise >= 0)
                check(k - last_rise == n, req_of(code), "high time",
                      k - last_rise, n);
            prev = div_out;
        end
    endtask

    initial begin
        void'($urandom(32'd20241));
        // Directed: every code, several full periods each.
        for (int c = 0; c < 8; c++) begin
            run_code(3'(c), 8 * exp_len(3'(c)) + 3);
        end
        // R5 vs code 3: same loop, phase outputs muted (R7).
        run_code(3'd3, 14);
        run_code(3'd0, 14);
        // Random codes and run lengths, each started from reset.
        for (int r = 0; r < 40; r++) begin
            run_code(3'($urandom % 8), 1 + int'($urandom % 40));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule